// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level translation table held in ordinary memory. A requester hands over one virtual address and an access kind (load, store or instruction fetch). The walker then fetches one top-level directory word and one leaf word through a single-word memory port. The directory base comes from a base register that software loads.

After the walk the walker reports exactly one outcome. It is either a physical address or a fault with a two-bit reason. The reason covers a missing directory entry, a missing leaf entry, or an access the leaf does not permit. When a permitted store reaches a leaf that is still clean, the walker writes that leaf back with its modified flag set before it reports completion. The memory can then tell which pages have been changed.

Every table word uses the same layout. Bits 31:12 hold a page number, either the next table's base or the final frame. Bit 0 is present, bit 1 allows loads, bit 2 allows stores, bit 3 allows fetches and bit 4 marks the page as modified. The walker handles one request at a time.

Top module: `pt_walker`

## Requirements
- R1: While reset is high and in the first idle cycle after it, req_ready is 1, done_valid is 0, mem_req_valid is 0, and the base register holds 0.
- R2: The first memory read of a walk goes to base + (vaddr[31:22] << 2). The base is the value the base register holds in the cycle the request is accepted.
- R3: When ptbr_we is high at a rising clock edge, the base register takes ptbr_wdata. Walks accepted afterwards use the new directory.
- R4: The second memory read of a walk goes to {dir[31:12], 12'h000} + (vaddr[21:12] << 2), where dir is the directory word just returned.
- R5: A directory word with bit 0 clear ends the walk with done_fault=1 and done_cause=2'b01. Only one memory read is issued.
- R6: A leaf word with bit 0 clear ends the walk with done_fault=1 and done_cause=2'b10.
- R7: Access code 2'b00 (load) needs leaf bit 1, 2'b01 (store) needs bit 2 and 2'b10 (fetch) needs bit 3. Code 2'b11 is never permitted. A refused access ends with done_fault=1 and done_cause=2'b11, and nothing is written to memory.
- R8: A permitted walk ends with done_fault=0, done_cause=2'b00 and done_paddr = {leaf[31:12], vaddr[11:0]}.
- R9: A permitted store whose leaf has bit 4 clear causes exactly one memory write before done_valid. The write goes to the leaf's own address, and its data is the leaf word with bit 4 set.
- R10: A permitted store to a leaf that already has bit 4 set, and any load or fetch, causes no memory write.
- R11: mem_req_valid stays high with stable address, write flag and write data until mem_req_ready is seen. A read response is used only after its request has been taken, however long the memory stalls.
- R12: Each accepted request produces exactly one single-cycle done_valid pulse. req_ready is low from acceptance through that pulse, and a request presented meanwhile is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptbr_we | input | 1 | Load strobe for the directory base register |
| ptbr_wdata | input | 32 | New directory base address |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and taking a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 00 load, 01 store, 10 fetch, 11 reserved |
| mem_req_valid | output | 1 | Memory access request |
| mem_req_ready | input | 1 | Memory takes the request this cycle |
| mem_req_we | output | 1 | 1 = write of a table word, 0 = read |
| mem_req_addr | output | 32 | Byte address of the table word |
| mem_req_wdata | output | 32 | Table word to write |
| mem_rsp_valid | input | 1 | Read data returned this cycle |
| mem_rsp_rdata | input | 32 | Returned table word |
| done_valid | output | 1 | One-cycle outcome strobe |
| done_fault | output | 1 | Walk ended in a fault |
| done_cause | output | 2 | 00 none, 01 directory absent, 10 leaf absent, 11 access refused |
| done_paddr | output | 32 | Translated physical address |

## Verification
The hardest case to reach is the modified-flag write-back while the memory throttles the port. To get there, a permitted store must land on a clean leaf at the same moment the memory both refuses requests on alternate cycles and delays its read data. The bench gets there by switching its memory model into a stall mode that toggles mem_req_ready and holds each response back by two cycles. It then runs a store to a fresh clean page and checks the written word and the returned address. A second hard-to-reach case is a request held on the port during a walk, which must not start a second walk. The bench keeps req_valid high with a different address until the outcome appears, then counts the memory reads.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_DIR,
    WS_LEAF,
    WS_MARK,
    WS_DONE
  } walk_state_e;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  // table word flag positions
  localparam int unsigned E_VALID = 0;
  localparam int unsigned E_READ  = 1;
  localparam int unsigned E_WRITE = 2;
  localparam int unsigned E_EXEC  = 3;
  localparam int unsigned E_DIRTY = 4;

  // outcome reason codes
  localparam logic [1:0] FC_NONE = 2'b00;
  localparam logic [1:0] FC_DIR  = 2'b01;
  localparam logic [1:0] FC_LEAF = 2'b10;
  localparam logic [1:0] FC_PERM = 2'b11;

endpackage

// File: rtl/pt_index_addr.sv
// Table word address: base plus index scaled by the entry size.
module pt_index_addr #(
  parameter int unsigned AW      = 32,
  parameter int unsigned IDX_W   = 10,
  parameter int unsigned ENT_LOG = 2
) (
  input  logic [AW-1:0]    base,
  input  logic [IDX_W-1:0] idx,
  output logic [AW-1:0]    addr
);
  localparam int unsigned PAD = AW - IDX_W - ENT_LOG;

  assign addr = base + {{PAD{1'b0}}, idx, {ENT_LOG{1'b0}}};

endmodule

// File: rtl/pt_perm_check.sv
// Decides whether a leaf word allows the access, and whether a store must mark it.
module pt_perm_check import pt_walker_pkg::*; #(
  parameter int unsigned EW = 32
) (
  input  logic [EW-1:0] entry,
  input  logic [1:0]    acc,
  output logic          allowed,
  output logic          want_dirty
);
  always_comb begin
    unique case (acc_kind_e'(acc))
      ACC_LOAD:  allowed = entry[E_READ];
      ACC_STORE: allowed = entry[E_WRITE];
      ACC_FETCH: allowed = entry[E_EXEC];
      default:   allowed = 1'b0;
    endcase
    want_dirty = (acc_kind_e'(acc) == ACC_STORE) && !entry[E_DIRTY];
  end

endmodule

// File: rtl/pt_walk_ctrl.sv
// Sequencer: one outstanding table access at a time.
module pt_walk_ctrl import pt_walker_pkg::*; #(
  parameter int unsigned AW    = 32,
  parameter int unsigned OFS_W = 12,
  parameter int unsigned IDX_W = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [OFS_W+IDX_W-1:0] req_low,
  input  logic [1:0]             req_acc,
  output logic                   req_ready,
  input  logic [AW-1:0]          dir_addr,
  input  logic [AW-1:0]          leaf_addr,
  input  logic                   perm_ok,
  input  logic                   want_dirty,
  output logic [IDX_W-1:0]       leaf_idx,
  output logic [1:0]             acc_held,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  output logic                   mem_req_we,
  output logic [AW-1:0]          mem_req_addr,
  output logic [AW-1:0]          mem_req_wdata,
  input  logic                   mem_rsp_valid,
  input  logic [AW-1:0]          mem_rsp_rdata,
  output logic                   done_valid,
  output logic                   done_fault,
  output logic [1:0]             done_cause,
  output logic [AW-1:0]          done_paddr
);
  localparam int unsigned LOW_W = OFS_W + IDX_W;

  walk_state_e      state_q;
  logic             pend_q;
  logic [LOW_W-1:0] low_q;
  logic [1:0]       acc_q;
  logic [AW-1:0]    addr_q;
  logic [AW-1:0]    wdata_q;
  logic             dv_q;
  logic             df_q;
  logic [1:0]       dc_q;
  logic [AW-1:0]    dp_q;

  logic             entry_ok;
  logic [AW-1:0]    leaf_pa;

  assign entry_ok = mem_rsp_rdata[E_VALID];
  assign leaf_pa  = {mem_rsp_rdata[AW-1:OFS_W], low_q[OFS_W-1:0]};

  assign req_ready     = (state_q == WS_IDLE);
  assign mem_req_valid = (((state_q == WS_DIR) || (state_q == WS_LEAF)) && !pend_q)
                         || (state_q == WS_MARK);
  assign mem_req_we    = (state_q == WS_MARK);
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = wdata_q;
  assign leaf_idx      = low_q[LOW_W-1:OFS_W];
  assign acc_held      = acc_q;
  assign done_valid    = dv_q;
  assign done_fault    = df_q;
  assign done_cause    = dc_q;
  assign done_paddr    = dp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WS_IDLE;
      pend_q  <= 1'b0;
      low_q   <= '0;
      acc_q   <= 2'b00;
      addr_q  <= '0;
      wdata_q <= '0;
      dv_q    <= 1'b0;
      df_q    <= 1'b0;
      dc_q    <= FC_NONE;
      dp_q    <= '0;
    end else begin
      dv_q <= 1'b0;
      unique case (state_q)
        WS_IDLE: begin
          if (req_valid) begin
            low_q   <= req_low;
            acc_q   <= req_acc;
            addr_q  <= dir_addr;
            pend_q  <= 1'b0;
            state_q <= WS_DIR;
          end
        end
        WS_DIR: begin
          if (!pend_q) begin
            if (mem_req_ready) pend_q <= 1'b1;
          end else if (mem_rsp_valid) begin
            pend_q <= 1'b0;
            if (!entry_ok) begin
              state_q <= WS_DONE;
              dv_q    <= 1'b1;
              df_q    <= 1'b1;
              dc_q    <= FC_DIR;
              dp_q    <= '0;
            end else begin
              addr_q  <= leaf_addr;
              state_q <= WS_LEAF;
            end
          end
        end
        WS_LEAF: begin
          if (!pend_q) begin
            if (mem_req_ready) pend_q <= 1'b1;
          end else if (mem_rsp_valid) begin
            pend_q <= 1'b0;
            if (!entry_ok) begin
              state_q <= WS_DONE;
              dv_q    <= 1'b1;
              df_q    <= 1'b1;
              dc_q    <= FC_LEAF;
              dp_q    <= '0;
            end else if (!perm_ok) begin
              state_q <= WS_DONE;
              dv_q    <= 1'b1;
              df_q    <= 1'b1;
              dc_q    <= FC_PERM;
              dp_q    <= '0;
            end else if (want_dirty) begin
              wdata_q          <= mem_rsp_rdata;
              wdata_q[E_DIRTY] <= 1'b1;
              dp_q             <= leaf_pa;
              state_q          <= WS_MARK;
            end else begin
              state_q <= WS_DONE;
              dv_q    <= 1'b1;
              df_q    <= 1'b0;
              dc_q    <= FC_NONE;
              dp_q    <= leaf_pa;
            end
          end
        end
        WS_MARK: begin
          if (mem_req_ready) begin
            state_q <= WS_DONE;
            dv_q    <= 1'b1;
            df_q    <= 1'b0;
            dc_q    <= FC_NONE;
          end
        end
        WS_DONE: state_q <= WS_IDLE;
        default: state_q <= WS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker import pt_walker_pkg::*; #(
  parameter int unsigned VA_W    = 32,
  parameter int unsigned OFS_W   = 12,
  parameter int unsigned ENT_LOG = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ptbr_we,
  input  logic [VA_W-1:0] ptbr_wdata,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [1:0]      req_acc,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_we,
  output logic [VA_W-1:0] mem_req_addr,
  output logic [VA_W-1:0] mem_req_wdata,
  input  logic            mem_rsp_valid,
  input  logic [VA_W-1:0] mem_rsp_rdata,
  output logic            done_valid,
  output logic            done_fault,
  output logic [1:0]      done_cause,
  output logic [VA_W-1:0] done_paddr
);
  localparam int unsigned IDX_W = (VA_W - OFS_W) / 2;
  localparam int unsigned LOW_W = OFS_W + IDX_W;

  logic [VA_W-1:0]  ptbr_q;
  logic [VA_W-1:0]  dir_addr;
  logic [VA_W-1:0]  leaf_addr;
  logic [VA_W-1:0]  leaf_base;
  logic [IDX_W-1:0] leaf_idx;
  logic [1:0]       acc_held;
  logic             perm_ok;
  logic             want_dirty;

  always_ff @(posedge clk) begin
    if (rst)          ptbr_q <= '0;
    else if (ptbr_we) ptbr_q <= ptbr_wdata;
  end

  assign leaf_base = {mem_rsp_rdata[VA_W-1:OFS_W], {OFS_W{1'b0}}};

  pt_index_addr #(.AW(VA_W), .IDX_W(IDX_W), .ENT_LOG(ENT_LOG)) u_dir_addr (
    .base (ptbr_q),
    .idx  (req_vaddr[VA_W-1:LOW_W]),
    .addr (dir_addr)
  );

  pt_index_addr #(.AW(VA_W), .IDX_W(IDX_W), .ENT_LOG(ENT_LOG)) u_leaf_addr (
    .base (leaf_base),
    .idx  (leaf_idx),
    .addr (leaf_addr)
  );

  pt_perm_check #(.EW(VA_W)) u_perm (
    .entry      (mem_rsp_rdata),
    .acc        (acc_held),
    .allowed    (perm_ok),
    .want_dirty (want_dirty)
  );

  pt_walk_ctrl #(.AW(VA_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_low       (req_vaddr[LOW_W-1:0]),
    .req_acc       (req_acc),
    .req_ready     (req_ready),
    .dir_addr      (dir_addr),
    .leaf_addr     (leaf_addr),
    .perm_ok       (perm_ok),
    .want_dirty    (want_dirty),
    .leaf_idx      (leaf_idx),
    .acc_held      (acc_held),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_rdata (mem_rsp_rdata),
    .done_valid    (done_valid),
    .done_fault    (done_fault),
    .done_cause    (done_cause),
    .done_paddr    (done_paddr)
  );

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int unsigned VA_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic            mem_req_we,
  input logic [VA_W-1:0] mem_req_addr,
  input logic [VA_W-1:0] mem_req_wdata,
  input logic            done_valid,
  input logic            done_fault,
  input logic [1:0]      done_cause
);

  AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_req_valid); // R1

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata))); // R11

  AST_FAULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (done_valid && done_fault) |-> (done_cause != 2'b00)); // R5

  AST_OK_NO_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (done_valid && !done_fault) |-> (done_cause == 2'b00)); // R8

  AST_WB_MARKS_DIRTY: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_we) |-> mem_req_wdata[4]); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid); // R12

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R12

  AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> !req_ready); // R12

endmodule

bind pt_walker pt_walker_chk #(.VA_W(VA_W)) u_chk (.*);

// File: tb/sim_pt_walker.sv
module sim_pt_walker;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ptbr_we = 1'b0;
  logic [31:0] ptbr_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = 2'b00;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic        mem_req_we;
  logic [31:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_rdata;
  logic        done_valid;
  logic        done_fault;
  logic [1:0]  done_cause;
  logic [31:0] done_paddr;

  always #5 clk = ~clk;

  pt_walker u0 (
    .clk(clk), .rst(rst), .ptbr_we(ptbr_we), .ptbr_wdata(ptbr_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_acc(req_acc),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .done_valid(done_valid), .done_fault(done_fault), .done_cause(done_cause), .done_paddr(done_paddr)
  );

  // flags in a table word
  localparam logic [11:0] FV = 12'h001, FR = 12'h002, FW = 12'h004, FX = 12'h008, FD = 12'h010;
  localparam logic [31:0] BASE_A = 32'h0040_0000;
  localparam logic [31:0] BASE_B = 32'h0080_0000;
  localparam logic [31:0] VA_R = 32'h0040_1538;
  localparam logic [31:0] VA_W2 = 32'h0080_2ABC;
  localparam logic [31:0] VA_S = 32'h0080_3000;
  localparam logic [31:0] VA_TOP = 32'hFFFF_FFFF;
  localparam logic [31:0] VA_NODIR = 32'h0100_0000;
  localparam logic [31:0] VA_NOLEAF = 32'h0040_2000;

  logic [31:0] mem [logic [31:0]];
  int          n_tests = 0;
  int          n_fail = 0;
  int          n_rd = 0;
  int          n_wr = 0;
  logic [31:0] rd_log [8];
  logic [31:0] wr_addr_last = '0;
  logic [31:0] wr_data_last = '0;
  bit          stall_mode = 1'b0;

  logic        r_fault;
  logic [1:0]  r_cause;
  logic [31:0] r_paddr;
  logic        r_dv_after;
  logic        r_rdy_after;
  bit          r_rdy_busy;

  function automatic logic [31:0] rd_mem(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put_dir(input logic [31:0] base, input logic [31:0] va, input logic [19:0] tbl);
    mem[base + {20'h0, va[31:22], 2'b00}] = {tbl, FV};
  endtask

  task automatic put_leaf(input logic [19:0] tbl, input logic [31:0] va, input logic [19:0] ppn,
                          input logic [11:0] fl);
    mem[{tbl, 12'h000} + {20'h0, va[21:12], 2'b00}] = {ppn, fl};
  endtask

  // memory model: decides ready and answers reads on falling edges
  initial begin
    int tick = 0;
    int wait_cnt = 0;
    bit pend = 1'b0;
    logic [31:0] pend_addr = '0;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_rdata = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (wait_cnt != 0) wait_cnt--;
        else begin
          mem_rsp_valid = 1'b1;
          mem_rsp_rdata = rd_mem(pend_addr);
          pend = 1'b0;
        end
      end
      tick++;
      mem_req_ready = !stall_mode || ((tick % 2) == 1);
      if (!rst && mem_req_valid && mem_req_ready) begin
        if (mem_req_we) begin
          mem[mem_req_addr] = mem_req_wdata;
          wr_addr_last = mem_req_addr;
          wr_data_last = mem_req_wdata;
          n_wr++;
        end else begin
          pend = 1'b1;
          pend_addr = mem_req_addr;
          wait_cnt = stall_mode ? 2 : 0;
          rd_log[n_rd % 8] = mem_req_addr;
          n_rd++;
        end
      end
    end
  end

  task automatic load_base(input logic [31:0] b);
    @(negedge clk);
    ptbr_we = 1'b1;
    ptbr_wdata = b;
    @(negedge clk);
    ptbr_we = 1'b0;
  endtask

  task automatic walk(input logic [31:0] va, input logic [1:0] acc, input bit hold, input logic [31:0] other);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    req_acc = acc;
    @(negedge clk);
    if (hold) begin
      req_vaddr = other;
      req_acc = 2'b00;
    end else req_valid = 1'b0;
    r_rdy_busy = 1'b0;
    while (!done_valid) begin
      if (req_ready) r_rdy_busy = 1'b1;
      @(negedge clk);
    end
    r_fault = done_fault;
    r_cause = done_cause;
    r_paddr = done_paddr;
    req_valid = 1'b0;
    @(negedge clk);
    r_dv_after = done_valid;
    r_rdy_after = req_ready;
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1 req_ready in reset", {31'h0, req_ready}, 32'h1);
    chk(done_valid == 1'b0, "R1 done_valid in reset", {31'h0, done_valid}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid idle", {31'h0, mem_req_valid}, 32'h0);
    chk(req_ready == 1'b1, "R1 req_ready idle", {31'h0, req_ready}, 32'h1);
  endtask

  task automatic t_reset_base();
    // base register is 0 after reset: directory index 0 read lands at address 0
    int rd0 = n_rd;
    walk(32'h0000_0000, 2'b00, 1'b0, '0);
    chk(rd_log[rd0 % 8] == 32'h0, "R1 base reset value", rd_log[rd0 % 8], 32'h0);
    chk(r_cause == 2'b01, "R5 empty directory at base 0", {30'h0, r_cause}, 32'h1);
  endtask

  task automatic t_read_ok();
    int rd0 = n_rd;
    walk(VA_R, 2'b00, 1'b0, '0);
    chk(r_fault == 1'b0 && r_cause == 2'b00, "R8 load ok status", {29'h0, r_fault, r_cause}, 32'h0);
    chk(r_paddr == 32'h4123_B538, "R8 load paddr", r_paddr, 32'h4123_B538);
    chk(n_rd - rd0 == 2, "R4 two reads per walk", n_rd - rd0, 32'd2);
    chk(rd_log[rd0 % 8] == 32'h0040_0004, "R2 directory address", rd_log[rd0 % 8], 32'h0040_0004);
    chk(rd_log[(rd0 + 1) % 8] == 32'h0012_3004, "R4 leaf address", rd_log[(rd0 + 1) % 8], 32'h0012_3004);
    chk(!r_dv_after && r_rdy_after, "R12 single pulse then idle", {30'h0, r_dv_after, r_rdy_after}, 32'h1);
  endtask

  task automatic t_perm_faults();
    int wr0 = n_wr;
    walk(VA_R, 2'b10, 1'b0, '0);
    chk(r_fault && r_cause == 2'b11, "R7 fetch without X", {29'h0, r_fault, r_cause}, 32'h7);
    walk(VA_R, 2'b01, 1'b0, '0);
    chk(r_fault && r_cause == 2'b11, "R7 store without W", {29'h0, r_fault, r_cause}, 32'h7);
    chk(n_wr == wr0, "R7 refused store writes nothing", n_wr - wr0, 32'd0);
    walk(VA_TOP, 2'b00, 1'b0, '0);
    chk(r_fault && r_cause == 2'b11, "R7 load without R", {29'h0, r_fault, r_cause}, 32'h7);
    walk(VA_TOP, 2'b10, 1'b0, '0);
    chk(!r_fault && r_paddr == 32'hABCD_EFFF, "R8 fetch at top index and offset", r_paddr, 32'hABCD_EFFF);
  endtask

  task automatic t_write_dirty();
    int wr0 = n_wr;
    walk(VA_W2, 2'b01, 1'b0, '0);
    chk(!r_fault && r_paddr == 32'h5555_5ABC, "R8 store paddr", r_paddr, 32'h5555_5ABC);
    chk(n_wr - wr0 == 1, "R9 one write-back", n_wr - wr0, 32'd1);
    chk(wr_addr_last == 32'h0012_4008, "R9 write-back address", wr_addr_last, 32'h0012_4008);
    chk(wr_data_last == 32'h5555_5017, "R9 write-back data", wr_data_last, 32'h5555_5017);
  endtask

  task automatic t_no_extra_write();
    int wr0 = n_wr;
    walk(VA_W2, 2'b01, 1'b0, '0);
    chk(!r_fault && n_wr == wr0, "R10 dirty store no write", n_wr - wr0, 32'd0);
    walk(VA_W2, 2'b00, 1'b0, '0);
    chk(!r_fault && n_wr == wr0, "R10 load no write", n_wr - wr0, 32'd0);
    walk(VA_W2, 2'b11, 1'b0, '0);
    chk(r_fault && r_cause == 2'b11 && n_wr == wr0, "R7 reserved access refused",
        {29'h0, r_fault, r_cause}, 32'h7);
  endtask

  task automatic t_bad_dir();
    int rd0 = n_rd;
    walk(VA_NODIR, 2'b00, 1'b0, '0);
    chk(r_fault && r_cause == 2'b01, "R5 absent directory", {29'h0, r_fault, r_cause}, 32'h5);
    chk(n_rd - rd0 == 1, "R5 only one read", n_rd - rd0, 32'd1);
  endtask

  task automatic t_bad_leaf();
    int rd0 = n_rd;
    walk(VA_NOLEAF, 2'b00, 1'b0, '0);
    chk(r_fault && r_cause == 2'b10, "R6 absent leaf", {29'h0, r_fault, r_cause}, 32'h6);
    chk(n_rd - rd0 == 2, "R6 two reads", n_rd - rd0, 32'd2);
  endtask

  task automatic t_base_switch();
    load_base(BASE_B);
    walk(VA_R, 2'b00, 1'b0, '0);
    chk(!r_fault && r_paddr == 32'h7777_7538, "R3 second directory", r_paddr, 32'h7777_7538);
    load_base(BASE_A);
    walk(VA_R, 2'b00, 1'b0, '0);
    chk(!r_fault && r_paddr == 32'h4123_B538, "R3 first directory again", r_paddr, 32'h4123_B538);
  endtask

  task automatic t_stall();
    int wr0 = n_wr;
    stall_mode = 1'b1;
    walk(VA_R, 2'b00, 1'b0, '0);
    chk(!r_fault && r_paddr == 32'h4123_B538, "R11 load under stalls", r_paddr, 32'h4123_B538);
    walk(VA_S, 2'b01, 1'b0, '0);
    chk(!r_fault && r_paddr == 32'h1357_9000, "R11 store under stalls", r_paddr, 32'h1357_9000);
    chk(n_wr - wr0 == 1 && rd_mem(32'h0012_400C) == 32'h1357_9015, "R9 write-back under stalls",
        rd_mem(32'h0012_400C), 32'h1357_9015);
    stall_mode = 1'b0;
  endtask

  task automatic t_busy_ignore();
    int rd0 = n_rd;
    walk(VA_R, 2'b00, 1'b1, VA_NODIR);
    chk(!r_fault && r_paddr == 32'h4123_B538, "R12 held request ignored", r_paddr, 32'h4123_B538);
    chk(n_rd - rd0 == 2, "R12 no extra walk reads", n_rd - rd0, 32'd2);
    chk(r_rdy_busy == 1'b0, "R12 req_ready low while busy", {31'h0, r_rdy_busy}, 32'h0);
    chk(!r_dv_after && r_rdy_after, "R12 one pulse", {30'h0, r_dv_after, r_rdy_after}, 32'h1);
  endtask

  initial begin
    put_dir(BASE_A, VA_R, 20'h00123);
    put_leaf(20'h00123, VA_R, 20'h4123B, FV | FR);
    put_dir(BASE_A, VA_W2, 20'h00124);
    put_leaf(20'h00124, VA_W2, 20'h55555, FV | FR | FW);
    put_leaf(20'h00124, VA_S, 20'h13579, FV | FW);
    put_dir(BASE_A, VA_TOP, 20'h00125);
    put_leaf(20'h00125, VA_TOP, 20'hABCDE, FV | FX);
    put_dir(BASE_B, VA_R, 20'h00126);
    put_leaf(20'h00126, VA_R, 20'h77777, FV | FR);
    mem[BASE_A + 32'h0000_0040] = 32'h0000_0000;  // index 16 of directory A left absent
    repeat (3) @(posedge clk);
    t_reset();
    t_reset_base();
    load_base(BASE_A);
    t_read_ok();
    t_perm_faults();
    t_write_dirty();
    t_no_extra_write();
    t_bad_dir();
    t_bad_leaf();
    t_base_switch();
    t_stall();
    t_busy_ignore();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule